// File: doc/BRIEF.md
# Software Interrupt Request Forcing Block

This block lets host software raise any of the interrupt lines IRQ1 through IRQ15 on demand. Two byte-wide read/write force registers sit in a runtime register window. The window's base address is supplied by the configuration logic. Each force bit is active-low: writing 0 asserts the matching interrupt, and writing 1 withdraws it.

The block merges the forced requests with the interrupt levels from the other on-chip hardware. It delivers one active-high request level per IRQ to a downstream serial interrupt framer. A single configuration enable gates every forced request at once. While the enable is low, only the hardware levels reach the framer. The force registers are changed only by bus writes, and reads return their stored contents.

Top module: `swirq_gen`

## Requirements
- R1: After reset both force registers read 0xFF, and `irq_req` equals `hw_irq`.
- R2: The low register sits at offset 0x54 from `rt_base`. Its bits 7..1 drive IRQ7..IRQ1 (`irq_req[7:1]`). Writing 0 to one of these bits with `frc_en`=1 sets the matching `irq_req` bit from the cycle after the write edge.
- R3: The high register sits at offset 0x55. Its bits 7..0 drive IRQ15..IRQ8 (`irq_req[15:8]`), and a 0 asserts the matching IRQ in the same way as R2.
- R4: Writing 1 to a force bit withdraws the forced request. The output then follows `hw_irq` again.
- R5: While a force bit is 0 and `frc_en`=1, the matching `irq_req` bit is 1 whatever the matching `hw_irq` bit is.
- R6: While `frc_en`=0, `irq_req` equals `hw_irq`, and the stored force bits are kept.
- R7: Bit 0 of the low register is reserved. It always reads 1 and ignores writes.
- R8: When `bus_rd` is high at offset 0x54 or 0x55, `bus_rdata` returns the stored value combinationally and `rd_hit` is 1, regardless of `frc_en`.
- R9: An access at any other offset changes no register, leaves `rd_hit` at 0 and returns 0 on `bus_rdata`.
- R10: The offsets are decoded relative to the current `rt_base` (a 16-bit difference that wraps around), so moving the base moves the window.
- R11: Activity on `hw_irq` never changes the force registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rt_base | input | 16 | Runtime window base address from configuration |
| frc_en | input | 1 | Global enable for forced requests |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| rd_hit | output | 1 | Read claimed by this block |
| hw_irq | input | 15 | Hardware request levels for IRQ15..IRQ1, active-high |
| irq_req | output | 15 | Merged request levels for IRQ15..IRQ1, active-high |

## Verification
A corrupted force bit shows up on `irq_req` in the very next cycle while `frc_en` is high. When the enable is low, it shows up at the first read of its register. A decode fault, such as a wrong offset, a wrong base subtraction or a wrong byte lane, shows up as a write that lands in the wrong bit. It also shows up as a read that returns data or `rd_hit` at the wrong address. Comparing the ports on every cycle against a behavioural model catches both kinds of fault within one cycle of the access that exposes them.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_BYTES  = 2;
  localparam int unsigned N_IRQ    = 15;
  localparam logic [ADDR_W-1:0] WIN_OFS = 16'h0054;
  localparam logic [N_BYTES*BYTE_W-1:0] RSVD_MASK = 16'h0001;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/swirq_rst_sync.sv
module swirq_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb sync_d = {sync_q[DEPTH-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[DEPTH-1];
endmodule

// File: rtl/swirq_decode.sv
module swirq_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned N_BYTES = 2,
  parameter logic [ADDR_W-1:0] WIN_OFS = 16'h0054
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [ADDR_W-1:0]  rt_base,
  output logic [N_BYTES-1:0] hit
);
  logic [ADDR_W-1:0] rel;

  always_comb rel = bus_addr - rt_base;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_hit
    localparam logic [ADDR_W-1:0] OFS_K = WIN_OFS + ADDR_W'(k);
    assign hit[k] = (rel == OFS_K);
  end
endmodule

// File: rtl/swirq_force_regs.sv
module swirq_force_regs #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_BYTES = 2,
  parameter logic [N_BYTES*BYTE_W-1:0] RSVD_MASK = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_BYTES-1:0]          wr_sel,
  input  logic [BYTE_W-1:0]           wdata,
  output logic [N_BYTES*BYTE_W-1:0]   frc_q
);
  localparam int unsigned TOT_W = N_BYTES * BYTE_W;

  for (genvar b = 0; b < TOT_W; b++) begin : g_bit
    if (RSVD_MASK[b]) begin : g_rsvd
      assign frc_q[b] = 1'b1;
    end else begin : g_ff
      logic bit_en;
      logic bit_d;
      logic bit_q;

      always_comb begin
        bit_en = wr_sel[b / BYTE_W];
        bit_d  = wdata[b % BYTE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b1;
        else if (bit_en) bit_q <= bit_d;
      end

      assign frc_q[b] = bit_q;
    end
  end
endmodule

// File: rtl/swirq_merge.sv
module swirq_merge #(
  parameter int unsigned N_IRQ = 15
) (
  input  logic             frc_en,
  input  logic [N_IRQ:1]   frc_n,
  input  logic [N_IRQ:1]   hw_irq,
  output logic [N_IRQ:1]   irq_req
);
  for (genvar i = 1; i <= N_IRQ; i++) begin : g_irq
    logic forced;
    always_comb begin
      forced     = frc_en & ~frc_n[i];
      irq_req[i] = forced ? 1'b1 : hw_irq[i];
    end
  end
endmodule

// File: rtl/swirq_gen.sv
module swirq_gen
  import swirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       rt_base,
  input  logic              frc_en,
  input  logic [15:0]       bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              rd_hit,
  input  logic [15:1]       hw_irq,
  output logic [15:1]       irq_req
);
  localparam int unsigned TOT_W = N_BYTES * BYTE_W;

  logic               rst_sync_n;
  logic [N_BYTES-1:0] hit;
  logic [N_BYTES-1:0] wr_sel;
  logic [TOT_W-1:0]   frc_q;

  swirq_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  swirq_decode #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES), .WIN_OFS(WIN_OFS)) u_dec (
    .bus_addr(bus_addr), .rt_base(rt_base), .hit(hit)
  );

  always_comb wr_sel = hit & {N_BYTES{bus_wr}};

  swirq_force_regs #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .RSVD_MASK(RSVD_MASK)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_sel(wr_sel), .wdata(bus_wdata), .frc_q(frc_q)
  );

  swirq_merge #(.N_IRQ(N_IRQ)) u_merge (
    .frc_en(frc_en), .frc_n(frc_q[N_IRQ:1]), .hw_irq(hw_irq), .irq_req(irq_req)
  );

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < int'(N_BYTES); k++) begin
      if (bus_rd && hit[k]) bus_rdata = frc_q[k*BYTE_W +: BYTE_W];
    end
    rd_hit = bus_rd & (|hit);
  end
endmodule

// File: rtl/swirq_gen_chk.sv
module swirq_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frc_en,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [1:0]  hit,
  input logic [15:0] frc_q,
  input logic [15:1] hw_irq,
  input logic [15:1] irq_req,
  input logic [7:0]  bus_rdata
);
  // R5
  force_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc_en |-> ((~frc_q[15:1] & ~irq_req) == 15'd0));

  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frc_en |-> (irq_req == hw_irq));

  // R7
  rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit[0]) |-> bus_rdata[0]);

  // R8
  read_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit[1]) |-> (bus_rdata == frc_q[15:8]));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (|hit)) |=> $stable(frc_q));
endmodule

bind swirq_gen swirq_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frc_en(frc_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .hit(hit), .frc_q(frc_q), .hw_irq(hw_irq), .irq_req(irq_req), .bus_rdata(bus_rdata)
);

// File: tb/tb_swirq_gen.sv
module tb_swirq_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] rt_base;
  logic        frc_en;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        rd_hit;
  logic [15:1] hw_irq;
  logic [15:1] irq_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] m_frc;

  always #4 clk = ~clk;

  swirq_gen dut (
    .clk(clk), .rst_n(rst_n), .rt_base(rt_base), .frc_en(frc_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rd_hit(rd_hit), .hw_irq(hw_irq), .irq_req(irq_req)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [15:0] addr, logic wr, logic rd, logic [7:0] wd);
    logic [15:0] rel;
    logic [15:1] exp_irq;
    logic [7:0]  exp_rd;
    logic        exp_hit;
    @(negedge clk);
    bus_addr = addr; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    #1;
    rel     = addr - rt_base;
    exp_irq = hw_irq;
    if (frc_en) exp_irq = exp_irq | ~m_frc[15:1];
    exp_hit = rd && (rel == 16'h0054 || rel == 16'h0055);
    exp_rd  = 8'h00;
    if (rd && rel == 16'h0054) exp_rd = m_frc[7:0];
    if (rd && rel == 16'h0055) exp_rd = m_frc[15:8];
    check(tag, "irq_req",   {1'b0, irq_req},   {1'b0, exp_irq});
    check(tag, "rd_hit",    {15'd0, rd_hit},   {15'd0, exp_hit});
    check(tag, "bus_rdata", {8'd0, bus_rdata}, {8'd0, exp_rd});
    @(posedge clk);
    if (wr && rel == 16'h0054) m_frc[7:0]  = {wd[7:1], 1'b1};
    if (wr && rel == 16'h0055) m_frc[15:8] = wd;
  endtask

  initial begin
    rst_n = 1'b0; rt_base = 16'h0300; frc_en = 1'b1;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    hw_irq = 15'h0000; m_frc = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    hw_irq = 15'h1234;
    step("R1", 16'h0354, 0, 1, 8'h00);
    step("R1", 16'h0355, 0, 1, 8'h00);
    hw_irq = 15'h0000;
    // R2 low register, IRQ1 and IRQ5
    step("R2", 16'h0354, 1, 0, 8'hDD);
    step("R2", 16'h0354, 0, 1, 8'h00);
    // R3 high register, IRQ15 and IRQ8
    step("R3", 16'h0355, 1, 0, 8'h7E);
    step("R3", 16'h0355, 0, 1, 8'h00);
    // R5 override against hardware levels both ways
    hw_irq = 15'h7FFF; step("R5", 16'h0000, 0, 0, 8'h00);
    hw_irq = 15'h2A2A; step("R5", 16'h0000, 0, 0, 8'h00);
    // R6 and R8 enable off, values kept and readable
    frc_en = 1'b0;
    step("R6", 16'h0000, 0, 0, 8'h00);
    step("R8", 16'h0354, 0, 1, 8'h00);
    step("R8", 16'h0355, 0, 1, 8'h00);
    frc_en = 1'b1;
    step("R6", 16'h0000, 0, 0, 8'h00);
    // R7 reserved bit
    step("R7", 16'h0354, 1, 0, 8'h00);
    step("R7", 16'h0354, 0, 1, 8'h00);
    // R9 neighbouring offsets
    step("R9", 16'h0353, 1, 1, 8'hFF);
    step("R9", 16'h0356, 1, 1, 8'hFF);
    step("R9", 16'h0354, 0, 1, 8'h00);
    step("R9", 16'h0355, 0, 1, 8'h00);
    // R10 relocated base, including wraparound
    rt_base = 16'hFFF0;
    step("R10", 16'h0354, 0, 1, 8'h00);
    step("R10", 16'h0045, 1, 1, 8'hA5);
    step("R10", 16'h0045, 0, 1, 8'h00);
    rt_base = 16'h0A00;
    step("R10", 16'h0A54, 1, 1, 8'h0F);
    step("R10", 16'h0A54, 0, 1, 8'h00);
    // R11 hardware activity leaves registers alone
    for (int i = 0; i < 8; i++) begin
      hw_irq = 15'(i * 16'h1111);
      step("R11", 16'h0000, 0, 0, 8'h00);
    end
    step("R11", 16'h0A54, 0, 1, 8'h00);
    step("R11", 16'h0A55, 0, 1, 8'h00);
    // R4 withdraw all forces
    hw_irq = 15'h0101;
    step("R4", 16'h0A54, 1, 0, 8'hFF);
    step("R4", 16'h0A55, 1, 0, 8'hFF);
    step("R4", 16'h0A54, 0, 1, 8'h00);
    step("R4", 16'h0A55, 0, 1, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule